// File: doc/BRIEF.md
# Unaligned Buffer Word Aligner

The block sits between the read path of a byte-addressed memory and a transmit FIFO whose entries are 36 bits wide: a 4-bit tag over a 32-bit payload. A sequencer feeds it a stream of items. Each item is one of four kinds: a command word, a fetched data word, an end-of-packet marker, or an under-run abort. A packet opens with a start command that carries the byte offset of the packet buffer inside its first word. The block packs the valid bytes of the fetched words into whole 32-bit data entries, whatever that offset is. It passes command words through untouched.

When a packet ends, any leftover bytes are pushed as a final zero-padded data word. An end-of-packet entry follows, which records the byte count of the last data word and whether the packet was aborted. Writing that entry returns the aligner to idle. An under-run abort drains in exactly the same way. A command that arrives while a packet is still open forces an aborted close first. In both cases the next command can never be merged with bytes left over from the previous packet.

All outputs are combinational from the item being presented and the block's state, so a word that fills a whole entry is written in the cycle it is presented. A ready signal from the FIFO back-pressures the block, and the block back-pressures the sequencer with its own ready.

Top module: `word_aligner`

## Requirements
- R1: Every FIFO entry is `{tag[3:0], payload[31:0]}`, with the tag in bits 35:32. Data entries carry tag 0x8, end-of-packet entries carry tag 0x1, and command entries carry the tag supplied with the command. The input kind is encoded as 0 = command, 1 = data, 2 = end of packet, 3 = under-run.
- R2: While the aligner is idle, a command is written to the FIFO unmodified as `{in_tag, in_word}`. A command whose tag is 0x0 (start of packet) also opens a packet and latches `in_ofs` as the byte offset of its first data word.
- R3: Byte lane i of a word is bits 8i+7:8i. The first data word of a packet contributes `in_nbytes` bytes starting at lane `in_ofs`, and every later data word contributes `in_nbytes` bytes starting at lane 0, with `in_ofs + in_nbytes <= 4`. Bytes are packed in arrival order from lane 0 upward, and a data entry is written each time four bytes have been collected.
- R4: On an end-of-packet item, 1 to 3 held bytes are first written as a data entry with the unused upper lanes zero. An end-of-packet entry follows. Its payload bits 2:0 give the byte count of the packet's last data entry (4 for a full entry, 0 if the packet wrote no data), and its payload bit 31 is 0.
- R5: An under-run item drains exactly like R4, except that payload bit 31 of the end-of-packet entry is 1. After that entry the aligner is idle and holds no bytes.
- R6: A command presented while a packet is open is held back. The open packet is first closed as in R5 (bit 31 = 1), and the command is then written unmodified.
- R7: While idle, data, end-of-packet and under-run items are accepted (`in_ready` = 1) and produce no FIFO entry.
- R8: A data word that completes four bytes (for example a full word at offset 0) raises `out_valid` with its entry in the same cycle it is presented, with no register in the path.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the entry stays stable until it is taken. No byte is lost or duplicated under back-pressure.
- R10: After reset the aligner is idle, holds no bytes and presents no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An item is presented |
| in_ready | output | 1 | The presented item is consumed at this edge |
| in_kind | input | 2 | Item kind: 0 command, 1 data, 2 end of packet, 3 under-run |
| in_tag | input | 4 | Tag written with a command item |
| in_word | input | 32 | Command payload or fetched data word |
| in_ofs | input | 2 | Byte offset of the first data word, sampled with a start command |
| in_nbytes | input | 3 | Number of valid bytes in a data word |
| out_valid | output | 1 | A FIFO entry is presented |
| out_ready | input | 1 | The FIFO can take the entry |
| out_entry | output | 36 | FIFO entry, tag over payload |

## Verification
A wrong residual count or byte buffer shows at the ports on the next data entry: bytes are shifted, duplicated or zero, and the fault is visible within one word of the wrong state. A packet-state flag stuck open or closed shows in one of three ways. Ignored items leak entries, a command loses its pass-through, or the end-of-packet entry goes missing, and each of these appears at the next item of the matching kind. A stale last-count or abort flag appears only in the end-of-packet payload, so the stimulus closes packets of every residual length through both the normal end and the under-run path.

// File: rtl/wa_pkg.sv
package wa_pkg;
  typedef enum logic [1:0] {
    K_CMD   = 2'd0,
    K_DATA  = 2'd1,
    K_END   = 2'd2,
    K_UNDER = 2'd3
  } kind_e;

  localparam logic [3:0] TAG_SOP  = 4'h0;
  localparam logic [3:0] TAG_DATA = 4'h8;
  localparam logic [3:0] TAG_EOP  = 4'h1;
endpackage

// File: rtl/wa_merge.sv
// Funnel that appends the valid bytes of a fetched word to the held residue.
module wa_merge #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-9:0]                  res_bytes,
  input  logic [$clog2(DW/8+1)-1:0]      res_cnt,
  input  logic [DW-1:0]                  word,
  input  logic [$clog2(DW/8)-1:0]        lo,
  input  logic [$clog2(DW/8+1)-1:0]      nbytes,
  output logic [DW-1:0]                  full_word,
  output logic [DW-9:0]                  spill,
  output logic [$clog2(DW/8+1):0]        total
);
  localparam int unsigned BYTES = DW / 8;
  localparam int unsigned CW    = $clog2(BYTES + 1);
  localparam int unsigned RES_W = DW - 8;
  localparam int unsigned CBW   = DW + RES_W;

  logic [DW-1:0]    shifted;
  logic [DW-1:0]    masked;
  logic [RES_W-1:0] res_masked;
  logic [CBW-1:0]   combined;

  assign shifted = word >> {lo, 3'b000};

  // keep only the bytes the source declared valid
  for (genvar k = 0; k < BYTES; k++) begin : g_new
    localparam logic [CW-1:0] KI = CW'(k);
    assign masked[8*k +: 8] = (KI < nbytes) ? shifted[8*k +: 8] : 8'h00;
  end

  for (genvar k = 0; k < BYTES - 1; k++) begin : g_res
    localparam logic [CW-1:0] KI = CW'(k);
    assign res_masked[8*k +: 8] = (KI < res_cnt) ? res_bytes[8*k +: 8] : 8'h00;
  end

  assign combined = {{DW{1'b0}}, res_masked}
                  | ({{RES_W{1'b0}}, masked} << {res_cnt, 3'b000});

  assign full_word = combined[DW-1:0];
  assign spill     = combined[CBW-1:DW];
  assign total     = {1'b0, res_cnt} + {1'b0, nbytes};
endmodule

// File: rtl/wa_ctrl.sv
// Packet state, residue registers and the per-item write decision.
module wa_ctrl
  import wa_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [1:0]                   in_kind,
  input  logic [3:0]                   in_tag,
  input  logic [DW-1:0]                in_word,
  input  logic [$clog2(DW/8)-1:0]      in_ofs,
  input  logic                         out_ready,
  input  logic [DW-1:0]                m_full,
  input  logic [DW-9:0]                m_spill,
  input  logic [$clog2(DW/8+1):0]      m_total,
  output logic                         in_ready,
  output logic                         out_valid,
  output logic [3:0]                   out_tag,
  output logic [DW-1:0]                out_pay,
  output logic [DW-9:0]                res_bytes,
  output logic [$clog2(DW/8+1)-1:0]    res_cnt,
  output logic [$clog2(DW/8)-1:0]      lo,
  output logic                         pkt_open
);
  localparam int unsigned BYTES = DW / 8;
  localparam int unsigned CW    = $clog2(BYTES + 1);
  localparam int unsigned LW    = $clog2(BYTES);
  localparam int unsigned RES_W = DW - 8;
  localparam logic [CW:0]   BYTES_T = (CW+1)'(BYTES);
  localparam logic [CW-1:0] BYTES_C = CW'(BYTES);

  kind_e kind;
  assign kind = kind_e'(in_kind);

  logic             first_q, first_d;
  logic [LW-1:0]    ofs_q, ofs_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [RES_W-1:0] res_q, res_d;
  logic [CW-1:0]    last_q, last_d;
  logic             open_q, open_d;

  logic             emit;
  logic             abort;
  logic [CW:0]      left;
  logic [DW-1:0]    eop_pay;

  assign lo        = first_q ? ofs_q : '0;
  assign res_bytes = res_q;
  assign res_cnt   = cnt_q;
  assign pkt_open  = open_q;

  assign emit  = (m_total >= BYTES_T);
  assign left  = m_total - BYTES_T;
  assign abort = (kind != K_END);

  always_comb begin
    eop_pay          = '0;
    eop_pay[DW-1]    = abort;
    eop_pay[CW-1:0]  = last_q;
  end

  // next-state and output decision
  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_tag   = TAG_DATA;
    out_pay   = '0;
    first_d   = first_q;
    ofs_d     = ofs_q;
    cnt_d     = cnt_q;
    res_d     = res_q;
    last_d    = last_q;
    open_d    = open_q;

    if (!open_q) begin
      if (kind == K_CMD) begin
        out_valid = in_valid;
        out_tag   = in_tag;
        out_pay   = in_word;
        in_ready  = out_ready;
        if (in_valid && out_ready && (in_tag == TAG_SOP)) begin
          open_d  = 1'b1;
          first_d = 1'b1;
          ofs_d   = in_ofs;
          cnt_d   = '0;
          res_d   = '0;
          last_d  = '0;
        end
      end else begin
        in_ready = 1'b1;
      end
    end else if (kind == K_DATA) begin
      out_valid = in_valid && emit;
      out_pay   = m_full;
      in_ready  = emit ? out_ready : 1'b1;
      if (in_valid && in_ready) begin
        first_d = 1'b0;
        if (emit) begin
          res_d  = m_spill;
          cnt_d  = left[CW-1:0];
          last_d = BYTES_C;
        end else begin
          res_d  = m_full[RES_W-1:0];
          cnt_d  = m_total[CW-1:0];
        end
      end
    end else if (cnt_q != '0) begin
      // drain held bytes before the end marker
      out_valid = in_valid;
      out_pay   = {8'h00, res_q};
      in_ready  = 1'b0;
      if (in_valid && out_ready) begin
        cnt_d  = '0;
        res_d  = '0;
        last_d = cnt_q;
      end
    end else begin
      out_valid = in_valid;
      out_tag   = TAG_EOP;
      out_pay   = eop_pay;
      in_ready  = (kind != K_CMD) && out_ready;
      if (in_valid && out_ready) begin
        open_d  = 1'b0;
        first_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b0;
      ofs_q   <= '0;
      cnt_q   <= '0;
      res_q   <= '0;
      last_q  <= '0;
      open_q  <= 1'b0;
    end else begin
      first_q <= first_d;
      ofs_q   <= ofs_d;
      cnt_q   <= cnt_d;
      res_q   <= res_d;
      last_q  <= last_d;
      open_q  <= open_d;
    end
  end
endmodule

// File: rtl/word_aligner.sv
module word_aligner #(
  parameter int unsigned DW = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [1:0]                  in_kind,
  input  logic [3:0]                  in_tag,
  input  logic [DW-1:0]               in_word,
  input  logic [$clog2(DW/8)-1:0]     in_ofs,
  input  logic [$clog2(DW/8+1)-1:0]   in_nbytes,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [DW+3:0]               out_entry
);
  localparam int unsigned BYTES = DW / 8;
  localparam int unsigned CW    = $clog2(BYTES + 1);
  localparam int unsigned LW    = $clog2(BYTES);
  localparam int unsigned RES_W = DW - 8;

  logic [RES_W-1:0] res_bytes;
  logic [CW-1:0]    res_cnt;
  logic [LW-1:0]    lo;
  logic             pkt_open;
  logic [DW-1:0]    m_full;
  logic [RES_W-1:0] m_spill;
  logic [CW:0]      m_total;
  logic [3:0]       out_tag;
  logic [DW-1:0]    out_pay;

  wa_merge #(.DW(DW)) u_merge (
    .res_bytes (res_bytes),
    .res_cnt   (res_cnt),
    .word      (in_word),
    .lo        (lo),
    .nbytes    (in_nbytes),
    .full_word (m_full),
    .spill     (m_spill),
    .total     (m_total)
  );

  wa_ctrl #(.DW(DW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_kind   (in_kind),
    .in_tag    (in_tag),
    .in_word   (in_word),
    .in_ofs    (in_ofs),
    .out_ready (out_ready),
    .m_full    (m_full),
    .m_spill   (m_spill),
    .m_total   (m_total),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_tag   (out_tag),
    .out_pay   (out_pay),
    .res_bytes (res_bytes),
    .res_cnt   (res_cnt),
    .lo        (lo),
    .pkt_open  (pkt_open)
  );

  assign out_entry = {out_tag, out_pay};
endmodule

// File: rtl/wa_checker.sv
module wa_checker #(
  parameter int unsigned DW = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic [1:0]                 in_kind,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [DW+3:0]              out_entry,
  input logic                       pkt_open,
  input logic [$clog2(DW/8+1)-1:0]  res_cnt
);
  localparam int unsigned BYTES = DW / 8;

  // R9: a stalled entry is held unchanged
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_entry)));

  // R9: nothing consumed while a write is blocked
  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R3: the residue never reaches a whole word
  assert_res_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_cnt < BYTES);

  // R4: the end marker is written only once the residue is drained
  assert_eop_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_entry[DW+3:DW] == 4'h1) |-> (res_cnt == '0));

  // R5: a written end marker leaves the aligner idle
  assert_eop_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_entry[DW+3:DW] == 4'h1) |=> !pkt_open);

  // R7: non-command items are swallowed while idle
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_open && in_valid && in_kind != 2'd0) |-> (!out_valid && in_ready));
endmodule

bind word_aligner wa_checker #(.DW(32)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_kind   (in_kind),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_entry (out_entry),
  .pkt_open  (pkt_open),
  .res_cnt   (res_cnt)
);

// File: tb/tb_word_aligner.sv
`timescale 1ns/100ps
module tb_word_aligner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_kind = 2'd0;
  logic [3:0]  in_tag = 4'h0;
  logic [31:0] in_word = 32'h0;
  logic [1:0]  in_ofs = 2'd0;
  logic [2:0]  in_nbytes = 3'd0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [35:0] out_entry;

  always #2 clk = ~clk;

  word_aligner dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_tag(in_tag), .in_word(in_word), .in_ofs(in_ofs),
    .in_nbytes(in_nbytes), .out_valid(out_valid), .out_ready(out_ready),
    .out_entry(out_entry)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit bp_en = 1'b0;
  bit done = 1'b0;

  // behavioural reference
  logic [35:0] exp_q[$];
  string       lab_q[$];
  byte unsigned bq[$];
  bit          m_open = 1'b0;
  bit          m_first = 1'b0;
  int          m_ofs = 0;
  int          m_last = 0;
  logic [31:0] rng = 32'h1234_5678;

  function automatic logic [31:0] next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // R1: entry is {tag, payload}
  task automatic push_exp(input logic [3:0] tag, input logic [31:0] pay, input string lab);
    exp_q.push_back({tag, pay});
    lab_q.push_back(lab);
  endtask

  task automatic model_close(input bit ab, input string lab);
    logic [31:0] w;
    logic [31:0] p;
    if (bq.size() > 0) begin
      w = 32'h0;
      foreach (bq[i]) w[8*i +: 8] = bq[i];
      m_last = bq.size();
      bq.delete();
      push_exp(4'h8, w, lab);
    end
    p = 32'h0;
    p[31] = ab;
    p[2:0] = 3'(m_last);
    push_exp(4'h1, p, lab);
    m_open = 1'b0;
  endtask

  task automatic model_item(input int kind, input logic [3:0] tag, input logic [31:0] word,
                            input int ofs, input int nb);
    int lo;
    logic [31:0] w;
    case (kind)
      0: begin
        if (m_open) model_close(1'b1, "R6");
        push_exp(tag, word, m_open ? "R6" : "R2");
        if (tag == 4'h0) begin
          m_open = 1'b1; m_first = 1'b1; m_ofs = ofs; m_last = 0; bq.delete();
        end
      end
      1: if (m_open) begin
        lo = m_first ? m_ofs : 0;
        for (int k = 0; k < nb; k++) bq.push_back(word[8*(lo+k) +: 8]);
        m_first = 1'b0;
        while (bq.size() >= 4) begin
          w = {bq[3], bq[2], bq[1], bq[0]};
          for (int k = 0; k < 4; k++) void'(bq.pop_front());
          m_last = 4;
          push_exp(4'h8, w, "R1/R3");
        end
      end
      2: if (m_open) model_close(1'b0, "R4");
      default: if (m_open) model_close(1'b1, "R5");
    endcase
  endtask

  task automatic send(input int kind, input logic [3:0] tag, input logic [31:0] word,
                      input int ofs, input int nb, input bit chk_r8);
    bit was_idle;
    was_idle = !m_open;
    model_item(kind, tag, word, ofs, nb);
    @(negedge clk);
    in_valid = 1'b1; in_kind = 2'(kind); in_tag = tag; in_word = word;
    in_ofs = 2'(ofs); in_nbytes = 3'(nb);
    #1;
    if (chk_r8)
      check(out_valid && out_entry == {4'h8, word}, "R8", {3'b0, out_valid, 32'h0} | out_entry, {4'h8, word});
    if (was_idle && kind != 0)
      check(!out_valid && in_ready, "R7", {34'h0, out_valid, in_ready}, 36'h1);
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_pkt(input int ofs, input int len, input int endkind);
    int rem;
    int nb;
    bit first;
    send(0, 4'h0, next_rand() & 32'h00FF_FFFF, ofs, 0, 1'b0);
    rem = len;
    first = 1'b1;
    while (rem > 0) begin
      nb = first ? 4 - ofs : 4;
      if (nb > rem) nb = rem;
      send(1, 4'h0, next_rand(), ofs, nb, 1'b0);
      rem -= nb;
      first = 1'b0;
    end
    if (endkind >= 0) send(endkind, 4'h0, next_rand(), 0, 0, 1'b0);
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    out_ready <= bp_en ? ((cyc % 3) != 1) : 1'b1;
  end

  // compare every clock
  logic        prev_stall = 1'b0;
  logic [35:0] prev_entry = 36'h0;
  always @(negedge clk) begin
    #1.5;
    if (rst_n) begin
      if (prev_stall)
        check(out_valid && out_entry == prev_entry, "R9", out_entry, prev_entry);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", out_entry, 36'h0);
        end else begin
          check(out_entry == exp_q[0], lab_q[0], out_entry, exp_q[0]);
          void'(exp_q.pop_front());
          void'(lab_q.pop_front());
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_entry = out_entry;
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    wait (cyc > 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid, "R10", {35'h0, out_valid}, 36'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // R10/R7: items before any start command leave no trace
    send(1, 4'h0, 32'hDEAD_BEEF, 0, 4, 1'b0);
    send(3, 4'h0, 32'h0, 0, 0, 1'b0);
    // R2: non-start command in idle
    send(0, 4'h5, 32'hCAFE_0001, 0, 0, 1'b0);
    // R8: full word at offset 0 with no back-pressure
    send(0, 4'h0, 32'h0000_0100, 0, 0, 1'b0);
    send(1, 4'h0, 32'hA1B2_C3D4, 0, 4, 1'b1);
    send(2, 4'h0, 32'h0, 0, 0, 1'b0);
    idle(2);
    bp_en = 1'b1;
    // R3/R4: every offset and residue length, normal end
    for (int o = 0; o < 4; o++)
      for (int l = 0; l < 10; l += 3) send_pkt(o, l, 2);
    // R5: under-run with held bytes and without
    send_pkt(3, 6, 3);
    send_pkt(1, 7, 3);
    send_pkt(0, 8, 3);
    send(0, 4'h7, 32'h1357_9BDF, 0, 0, 1'b0);
    // R6: command while a packet is open
    send_pkt(2, 5, -1);
    send(0, 4'h3, 32'h0BAD_F00D, 0, 0, 1'b0);
    send_pkt(1, 2, -1);
    send(0, 4'h0, 32'h0000_0200, 2, 0, 1'b0);
    send(1, 4'h0, 32'h1122_3344, 2, 2, 1'b0);
    send(2, 4'h0, 32'h0, 0, 0, 1'b0);
    idle(1);
    for (int i = 0; i < 300 && exp_q.size() != 0; i++) @(negedge clk);
    #2;
    check(exp_q.size() == 0, "R9", 36'(exp_q.size()), 36'h0);
    done = 1'b1;
    finish_run();
  end
endmodule